// File: doc/BRIEF.md
# Security-Aware Instruction Fetch Lookup

This block sits in front of the instruction fetch path. One cycle does the whole lookup. The low bits of the fetch virtual address pick a line in a direct-mapped instruction store. In the same cycle, a small fully associative translation table turns the virtual page number into a physical page number. The physical tag then decides the hit. Each table entry records the security world it was loaded for, and a lookup only considers entries of the world the core is currently in. Each entry also holds a descriptor NS bit and two permissions: execute permission and user-mode permission.

When translation succeeds and the permission check passes, a matching line returns its word in the same cycle. A line matches when it is valid, its physical tag is equal, and its recorded NS value is equal. If the line does not match, the block issues a read on a valid/ready external port. That read carries the translated physical address and an effective NS attribute. A core in the Non-secure world always reads Non-secure. A core in the Secure world reads with the descriptor's NS bit. When the response arrives, the word is written into the line and passed to the fetch output in the same cycle.

A permission failure aborts the fetch with no external traffic. An absent translation raises a separate translation-miss flag. The core holds its request until the table is loaded through the write port.

Top module: `ifl_fetch_lookup`

## Requirements
- R1: A synchronous reset clears every translation entry and every line. After reset no output is active, any fetch reports a translation miss, and the first fetch after reloading the table goes to the external port.
- R2: An entry matches only if its world flag equals `core_ns` at the time of the lookup (0 = Secure, 1 = Non-secure). An entry of the other world gives a translation miss.
- R3: When no entry matches, `fetch_xlate_miss` is high in the lookup cycle. In that cycle `fetch_done` and `fetch_abort` stay low, and no external request follows.
- R4: The permission check passes only if the entry's execute bit is 1, and also its user bit is 1 whenever `fetch_user` is 1. On failure, `fetch_abort` is high in the lookup cycle, `fetch_done` stays low even if the line would match, and no external request follows.
- R5: A line hit gives `fetch_done` high in the lookup cycle, with the stored word on `fetch_data`.
- R6: On a line miss that passes the permission check, `mem_req_valid` rises one cycle after the lookup. It carries `mem_req_pa` = {physical page, virtual bits [PAGE_W-1:0]}, and address and attribute stay stable until `mem_req_ready` is seen.
- R7: A request made while `core_ns` is 1 has `mem_req_ns` = 1, whatever the descriptor NS bit is.
- R8: A request made while `core_ns` is 0 has `mem_req_ns` equal to the descriptor NS bit.
- R9: When `mem_rsp_valid` arrives after the request is accepted, `fetch_done` is high in that cycle with `fetch_data` = `mem_rsp_data`. The line is written, so the same fetch hits afterwards.
- R10: Each line records the effective NS value it was filled with. It hits only for a lookup with the same effective NS value, whichever world produced that value.
- R11: A table write takes effect one cycle after it is presented. A lookup in the same cycle sees the previous contents.
- R12: The line index comes from virtual address bits [OFF_W+IDX_W-1:OFF_W] and the stored tag from the physical address. Two virtual pages mapped to one physical page therefore share lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch request present, held until done, abort or translation miss |
| fetch_va | input | VA_W | Fetch virtual address |
| fetch_user | input | 1 | Fetch is made in user mode |
| core_ns | input | 1 | Core security world, 1 = Non-secure |
| fetch_done | output | 1 | Instruction word valid |
| fetch_data | output | DATA_W | Instruction word |
| fetch_abort | output | 1 | Permission check failed |
| fetch_xlate_miss | output | 1 | No translation entry for this world and page |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_slot | input | $clog2(TLB_N) | Entry slot written |
| tlb_wr_vpn | input | VA_W-PAGE_W | Virtual page number |
| tlb_wr_ppn | input | PA_W-PAGE_W | Physical page number |
| tlb_wr_world_ns | input | 1 | World the entry belongs to, 1 = Non-secure |
| tlb_wr_attr_ns | input | 1 | Descriptor NS bit |
| tlb_wr_exec_ok | input | 1 | Execute permitted |
| tlb_wr_user_ok | input | 1 | User-mode access permitted |
| mem_req_valid | output | 1 | External read request |
| mem_req_ready | input | 1 | External port accepts the request |
| mem_req_pa | output | PA_W | Physical address of the read |
| mem_req_ns | output | 1 | Effective NS attribute of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
Two events can land in the same cycle. The first is a table write arriving while a lookup of the same page is in progress. The bench raises the write strobe and the fetch on one edge. It expects a translation miss in that cycle and a valid translation in the next, and it drops the fetch before the following edge. The second is a returning response, which writes the line and also drives the fetch output in that cycle. The bench checks the forwarded word in the response cycle itself, then fetches again and expects a hit with the same word. The word is computed arithmetically from the physical address and the NS value. A mix-up between the write path and the forward path therefore shows up as a wrong value.

// File: rtl/ifl_pkg.sv
`timescale 1ns/1ps
package ifl_pkg;

   // miss sequencer states
   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_REQ  = 2'd1,
      MS_WAIT = 2'd2
   } ifl_mstate_e;

   // effective NS of an access: Non-secure world forces 1
   function automatic logic eff_ns(input logic world_ns, input logic desc_ns);
      return world_ns | desc_ns;
   endfunction

endpackage

// File: rtl/ifl_tlb.sv
`timescale 1ns/1ps
module ifl_tlb #(
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ENTRIES = 4,
   localparam int SLOT_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic              wr_world_ns,
   input  logic              wr_attr_ns,
   input  logic              wr_exec_ok,
   input  logic              wr_user_ok,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_world_ns,
   input  logic              lk_user,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic              hit_attr_ns,
   output logic              perm_ok
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ifl_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("ifl_tlb: page number widths must be positive");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [VPN_W-1:0]   vpn_q   [ENTRIES];
   logic [PPN_W-1:0]   ppn_q   [ENTRIES];
   logic [ENTRIES-1:0] world_q;
   logic [ENTRIES-1:0] attr_q;
   logic [ENTRIES-1:0] xok_q;
   logic [ENTRIES-1:0] uok_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_slot] <= 1'b1;
         vpn_q[wr_slot]   <= wr_vpn;
         ppn_q[wr_slot]   <= wr_ppn;
         world_q[wr_slot] <= wr_world_ns;
         attr_q[wr_slot]  <= wr_attr_ns;
         xok_q[wr_slot]   <= wr_exec_ok;
         uok_q[wr_slot]   <= wr_user_ok;
      end
   end

   // one comparator per entry, gated by the world the entry belongs to
   logic [ENTRIES-1:0] match;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (world_q[g] == lk_world_ns);
   end

   // lowest matching slot wins
   logic [SLOT_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (match[k]) sel = k[SLOT_W-1:0];
      end
   end

   assign hit         = |match;
   assign hit_ppn     = ppn_q[sel];
   assign hit_attr_ns = attr_q[sel];
   assign perm_ok     = xok_q[sel] && (!lk_user || uok_q[sel]);

   // R1: nothing translates in the first cycle after reset
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !hit);

   // R2: a reported translation always comes from an entry of the lookup world
   a_r2_world_gate: assert property (@(posedge clk) disable iff (rst)
      hit |-> (world_q[sel] == lk_world_ns));

endmodule

// File: rtl/ifl_line_array.sv
`timescale 1ns/1ps
module ifl_line_array #(
   parameter int IDX_W  = 4,
   parameter int PTAG_W = 26,
   parameter int DATA_W = 32,
   localparam int LINES = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_ns,
   output logic [PTAG_W-1:0] rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_ns,
   input  logic [PTAG_W-1:0] wr_tag,
   input  logic [DATA_W-1:0] wr_data
);

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("ifl_line_array: IDX_W out of range 1..10");
   end

   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  ns_q;
   logic [PTAG_W-1:0] tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         ns_q[wr_idx]    <= wr_ns;
         tag_q[wr_idx]   <= wr_tag;
         data_q[wr_idx]  <= wr_data;
      end
   end

   // read runs in the lookup cycle, alongside translation
   assign rd_valid = valid_q[rd_idx];
   assign rd_ns    = ns_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   // R9: a fill leaves its line valid
   a_r9_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/ifl_miss_ctrl.sv
`timescale 1ns/1ps
module ifl_miss_ctrl
   import ifl_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int LINE_LO = 6,
   localparam int PTAG_W = PA_W - LINE_LO
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  logic [PA_W-1:0]   launch_pa,
   input  logic              launch_ns,
   input  logic [IDX_W-1:0]  launch_idx,
   output logic              idle,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_pa,
   output logic              mem_req_ns,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              fill_en,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [PTAG_W-1:0] fill_tag,
   output logic              fill_ns,
   output logic [DATA_W-1:0] fill_data
);

   if (LINE_LO >= PA_W) begin : g_bad_lo
      $error("ifl_miss_ctrl: LINE_LO must be below PA_W");
   end

   ifl_mstate_e       state_q, state_d;
   logic [PA_W-1:0]   pa_q;
   logic              ns_q;
   logic [IDX_W-1:0]  idx_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         MS_IDLE: if (launch)        state_d = MS_REQ;
         MS_REQ:  if (mem_req_ready) state_d = MS_WAIT;
         MS_WAIT: if (mem_rsp_valid) state_d = MS_IDLE;
         default:                    state_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= MS_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == MS_IDLE && launch) begin
         pa_q  <= launch_pa;
         ns_q  <= launch_ns;
         idx_q <= launch_idx;
      end
   end

   assign idle          = (state_q == MS_IDLE);
   assign mem_req_valid = (state_q == MS_REQ);
   assign mem_req_pa    = pa_q;
   assign mem_req_ns    = ns_q;

   assign fill_en   = (state_q == MS_WAIT) && mem_rsp_valid;
   assign fill_idx  = idx_q;
   assign fill_tag  = pa_q[PA_W-1:LINE_LO];
   assign fill_ns   = ns_q;
   assign fill_data = mem_rsp_data;

   // R6: a launch is followed by a request in the next cycle
   a_r6_launch_to_req: assert property (@(posedge clk) disable iff (rst)
      (idle && launch) |=> mem_req_valid);

   // R6: address and attribute hold while the port stalls
   a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_pa) && $stable(mem_req_ns)));

   // R9: a response is only taken after the request was accepted
   a_r9_fill_after_accept: assert property (@(posedge clk) disable iff (rst)
      fill_en |-> !mem_req_valid);

endmodule

// File: rtl/ifl_fetch_lookup.sv
`timescale 1ns/1ps
module ifl_fetch_lookup
   import ifl_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int PAGE_W = 12,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int TLB_N  = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      fetch_valid,
   input  logic [VA_W-1:0]           fetch_va,
   input  logic                      fetch_user,
   input  logic                      core_ns,
   output logic                      fetch_done,
   output logic [DATA_W-1:0]         fetch_data,
   output logic                      fetch_abort,
   output logic                      fetch_xlate_miss,
   input  logic                      tlb_wr_en,
   input  logic [$clog2(TLB_N)-1:0]  tlb_wr_slot,
   input  logic [VA_W-PAGE_W-1:0]    tlb_wr_vpn,
   input  logic [PA_W-PAGE_W-1:0]    tlb_wr_ppn,
   input  logic                      tlb_wr_world_ns,
   input  logic                      tlb_wr_attr_ns,
   input  logic                      tlb_wr_exec_ok,
   input  logic                      tlb_wr_user_ok,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   output logic [PA_W-1:0]           mem_req_pa,
   output logic                      mem_req_ns,
   input  logic                      mem_rsp_valid,
   input  logic [DATA_W-1:0]         mem_rsp_data
);

   localparam int VPN_W   = VA_W - PAGE_W;
   localparam int PPN_W   = PA_W - PAGE_W;
   localparam int OFF_W   = $clog2(DATA_W / 8);
   localparam int LINE_LO = OFF_W + IDX_W;
   localparam int PTAG_W  = PA_W - LINE_LO;

   // index bits must sit inside the page offset so virtual and physical index agree
   if (LINE_LO > PAGE_W) begin : g_bad_alias
      $error("ifl_fetch_lookup: index bits exceed the page offset");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("ifl_fetch_lookup: DATA_W must be a power of two of at least 8");
   end
   if (PAGE_W >= VA_W || PAGE_W >= PA_W) begin : g_bad_page
      $error("ifl_fetch_lookup: PAGE_W must be below both address widths");
   end

   // ---------------- translation ----------------
   logic             tlb_hit;
   logic [PPN_W-1:0] tlb_ppn;
   logic             tlb_attr_ns;
   logic             tlb_perm_ok;

   ifl_tlb #(
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .ENTRIES (TLB_N)
   ) tlb_i (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (tlb_wr_en),
      .wr_slot     (tlb_wr_slot),
      .wr_vpn      (tlb_wr_vpn),
      .wr_ppn      (tlb_wr_ppn),
      .wr_world_ns (tlb_wr_world_ns),
      .wr_attr_ns  (tlb_wr_attr_ns),
      .wr_exec_ok  (tlb_wr_exec_ok),
      .wr_user_ok  (tlb_wr_user_ok),
      .lk_vpn      (fetch_va[VA_W-1:PAGE_W]),
      .lk_world_ns (core_ns),
      .lk_user     (fetch_user),
      .hit         (tlb_hit),
      .hit_ppn     (tlb_ppn),
      .hit_attr_ns (tlb_attr_ns),
      .perm_ok     (tlb_perm_ok)
   );

   // ---------------- line store, virtually indexed ----------------
   logic [IDX_W-1:0]  rd_idx;
   logic              ln_valid;
   logic              ln_ns;
   logic [PTAG_W-1:0] ln_tag;
   logic [DATA_W-1:0] ln_data;
   logic              fill_en;
   logic [IDX_W-1:0]  fill_idx;
   logic [PTAG_W-1:0] fill_tag;
   logic              fill_ns;
   logic [DATA_W-1:0] fill_data;

   assign rd_idx = fetch_va[LINE_LO-1:OFF_W];

   ifl_line_array #(
      .IDX_W  (IDX_W),
      .PTAG_W (PTAG_W),
      .DATA_W (DATA_W)
   ) lines_i (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (rd_idx),
      .rd_valid (ln_valid),
      .rd_ns    (ln_ns),
      .rd_tag   (ln_tag),
      .rd_data  (ln_data),
      .wr_en    (fill_en),
      .wr_idx   (fill_idx),
      .wr_ns    (fill_ns),
      .wr_tag   (fill_tag),
      .wr_data  (fill_data)
   );

   // ---------------- physical compare ----------------
   logic [PA_W-1:0]   phys_pa;
   logic [PTAG_W-1:0] phys_tag;
   logic              acc_ns;
   logic              line_match;
   logic              idle;
   logic              lookup;
   logic              line_hit;
   logic              launch;

   assign phys_pa    = {tlb_ppn, fetch_va[PAGE_W-1:0]};
   assign phys_tag   = phys_pa[PA_W-1:LINE_LO];
   assign acc_ns     = eff_ns(core_ns, tlb_attr_ns);
   assign line_match = ln_valid && (ln_tag == phys_tag) && (ln_ns == acc_ns);

   assign lookup           = fetch_valid && idle;
   assign fetch_xlate_miss = lookup && !tlb_hit;
   assign fetch_abort      = lookup && tlb_hit && !tlb_perm_ok;
   assign line_hit         = lookup && tlb_hit && tlb_perm_ok && line_match;
   assign launch           = lookup && tlb_hit && tlb_perm_ok && !line_match;

   // ---------------- miss path ----------------
   ifl_miss_ctrl #(
      .PA_W    (PA_W),
      .IDX_W   (IDX_W),
      .DATA_W  (DATA_W),
      .LINE_LO (LINE_LO)
   ) miss_i (
      .clk           (clk),
      .rst           (rst),
      .launch        (launch),
      .launch_pa     (phys_pa),
      .launch_ns     (acc_ns),
      .launch_idx    (rd_idx),
      .idle          (idle),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_pa    (mem_req_pa),
      .mem_req_ns    (mem_req_ns),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .fill_en       (fill_en),
      .fill_idx      (fill_idx),
      .fill_tag      (fill_tag),
      .fill_ns       (fill_ns),
      .fill_data     (fill_data)
   );

   // hit word from the array, or the response forwarded while it is written
   assign fetch_done = line_hit || fill_en;
   assign fetch_data = fill_en ? mem_rsp_data : ln_data;

   // R3: a translation miss is exclusive with data and abort
   a_r3_xmiss_quiet: assert property (@(posedge clk) disable iff (rst)
      fetch_xlate_miss |-> (!fetch_done && !fetch_abort));

   // R3: no external request follows a translation miss
   a_r3_xmiss_no_req: assert property (@(posedge clk) disable iff (rst)
      fetch_xlate_miss |=> !mem_req_valid);

   // R4: an abort never delivers data
   a_r4_abort_no_data: assert property (@(posedge clk) disable iff (rst)
      fetch_abort |-> !fetch_done);

   // R4: no external request follows an abort
   a_r4_abort_no_req: assert property (@(posedge clk) disable iff (rst)
      fetch_abort |=> !mem_req_valid);

   // R5: data from the array needs a passing translation
   a_r5_hit_needs_perm: assert property (@(posedge clk) disable iff (rst)
      (fetch_done && idle) |-> (tlb_hit && tlb_perm_ok));

   // R7: a request launched from the Non-secure world is Non-secure
   a_r7_ns_world: assert property (@(posedge clk) disable iff (rst)
      (launch && core_ns) |=> mem_req_ns);

   // R8: a request launched from the Secure world follows the descriptor
   a_r8_secure_attr: assert property (@(posedge clk) disable iff (rst)
      (launch && !core_ns) |=> (mem_req_ns == $past(tlb_attr_ns)));

endmodule

// File: tb/ifl_fetch_lookup_tb_top.sv
`timescale 1ns/1ps
module ifl_fetch_lookup_tb_top;

   localparam int B_IDX_W = 3;
   localparam int B_LINES = 1 << B_IDX_W;
   localparam int B_TLB_N = 4;
   localparam int B_LO    = B_IDX_W + 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_va = '0;
   logic        fetch_user = 1'b0;
   logic        core_ns = 1'b0;
   logic        fetch_done;
   logic [31:0] fetch_data;
   logic        fetch_abort;
   logic        fetch_xlate_miss;
   logic        tlb_wr_en = 1'b0;
   logic [1:0]  tlb_wr_slot = '0;
   logic [19:0] tlb_wr_vpn = '0;
   logic [19:0] tlb_wr_ppn = '0;
   logic        tlb_wr_world_ns = 1'b0;
   logic        tlb_wr_attr_ns = 1'b0;
   logic        tlb_wr_exec_ok = 1'b0;
   logic        tlb_wr_user_ok = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_pa;
   logic        mem_req_ns;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ifl_fetch_lookup #(
      .VA_W(32), .PA_W(32), .PAGE_W(12), .IDX_W(B_IDX_W), .DATA_W(32), .TLB_N(B_TLB_N)
   ) dut_i (
      .clk(clk), .rst(rst),
      .fetch_valid(fetch_valid), .fetch_va(fetch_va), .fetch_user(fetch_user), .core_ns(core_ns),
      .fetch_done(fetch_done), .fetch_data(fetch_data), .fetch_abort(fetch_abort),
      .fetch_xlate_miss(fetch_xlate_miss),
      .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot), .tlb_wr_vpn(tlb_wr_vpn),
      .tlb_wr_ppn(tlb_wr_ppn), .tlb_wr_world_ns(tlb_wr_world_ns), .tlb_wr_attr_ns(tlb_wr_attr_ns),
      .tlb_wr_exec_ok(tlb_wr_exec_ok), .tlb_wr_user_ok(tlb_wr_user_ok),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_pa(mem_req_pa),
      .mem_req_ns(mem_req_ns), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   // bench model of translation entries and lines
   logic        m_tv   [B_TLB_N];
   logic [19:0] m_tvpn [B_TLB_N];
   logic [19:0] m_tppn [B_TLB_N];
   logic        m_tw   [B_TLB_N];
   logic        m_ta   [B_TLB_N];
   logic        m_tx   [B_TLB_N];
   logic        m_tu   [B_TLB_N];
   logic        m_lv   [B_LINES];
   logic        m_lns  [B_LINES];
   logic [31:0] m_ltag [B_LINES];

   function automatic logic [31:0] word_of(input logic [31:0] pa, input logic ns);
      return pa ^ (ns ? 32'hC3C3_0F0F : 32'h1E1E_7070);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic model_clear();
      for (int i = 0; i < B_TLB_N; i++) m_tv[i] = 1'b0;
      for (int i = 0; i < B_LINES; i++) m_lv[i] = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   task automatic tlb_load(input int slot, input logic [19:0] vpn, input logic [19:0] ppn,
                           input logic w, input logic a, input logic x, input logic u);
      @(negedge clk);
      tlb_wr_en = 1'b1; tlb_wr_slot = slot[1:0]; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
      tlb_wr_world_ns = w; tlb_wr_attr_ns = a; tlb_wr_exec_ok = x; tlb_wr_user_ok = u;
      @(negedge clk);
      tlb_wr_en = 1'b0;
      m_tv[slot] = 1'b1; m_tvpn[slot] = vpn; m_tppn[slot] = ppn;
      m_tw[slot] = w; m_ta[slot] = a; m_tx[slot] = x; m_tu[slot] = u;
   endtask

   // one fetch, outcome predicted from the model
   task automatic run_fetch(input logic [31:0] va, input logic c, input logic usr,
                            input int rdy_dly, input int rsp_dly, input string ctx);
      bit found = 1'b0;
      int k = 0;
      logic ens, perm, lhit;
      logic [31:0] pa, dat;
      int li;
      for (int j = B_TLB_N - 1; j >= 0; j--)
         if (m_tv[j] && m_tvpn[j] == va[31:12] && m_tw[j] == c) begin found = 1'b1; k = j; end
      ens  = c | m_ta[k];
      perm = m_tx[k] && (!usr || m_tu[k]);
      pa   = {m_tppn[k], va[11:0]};
      dat  = word_of(pa, ens);
      li   = int'(va[B_LO-1:2]);
      lhit = m_lv[li] && (m_ltag[li] == {{B_LO{1'b0}}, pa[31:B_LO]}) && (m_lns[li] == ens);

      @(negedge clk);
      fetch_valid = 1'b1; fetch_va = va; core_ns = c; fetch_user = usr;
      #1;
      if (!found) begin
         // R3 / R2: translation miss, nothing else
         chk(fetch_xlate_miss == 1'b1, "R3", {ctx, " xlate miss flag"}, 64'(fetch_xlate_miss), 64'd1);
         chk(!fetch_done && !fetch_abort, "R3", {ctx, " quiet on xlate miss"},
             64'({fetch_done, fetch_abort}), 64'd0);
         @(negedge clk); fetch_valid = 1'b0; #1;
         chk(mem_req_valid == 1'b0, "R3", {ctx, " no request after xlate miss"}, 64'(mem_req_valid), 64'd0);
      end else if (!perm) begin
         // R4: abort, no data, no request
         chk(fetch_abort == 1'b1 && !fetch_done && !fetch_xlate_miss, "R4", {ctx, " abort"},
             64'({fetch_abort, fetch_done, fetch_xlate_miss}), 64'b100);
         @(negedge clk); fetch_valid = 1'b0; #1;
         chk(mem_req_valid == 1'b0, "R4", {ctx, " no request after abort"}, 64'(mem_req_valid), 64'd0);
      end else if (lhit) begin
         // R5: hit in lookup cycle
         chk(fetch_done == 1'b1 && fetch_data == dat, "R5", {ctx, " hit data"},
             {31'd0, fetch_done, fetch_data}, {31'd0, 1'b1, dat});
         @(negedge clk); fetch_valid = 1'b0; #1;
         chk(mem_req_valid == 1'b0, "R5", {ctx, " no request on hit"}, 64'(mem_req_valid), 64'd0);
      end else begin
         chk(!fetch_done && !fetch_abort && !fetch_xlate_miss, "R6", {ctx, " quiet miss cycle"},
             64'({fetch_done, fetch_abort, fetch_xlate_miss}), 64'd0);
         @(negedge clk); #1;
         chk(mem_req_valid && mem_req_pa == pa, "R6", {ctx, " request address"},
             {31'd0, mem_req_valid, mem_req_pa}, {31'd0, 1'b1, pa});
         chk(mem_req_ns == ens, c ? "R7" : "R8", {ctx, " request NS"}, 64'(mem_req_ns), 64'(ens));
         for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk); #1;
            chk(mem_req_valid && mem_req_pa == pa && mem_req_ns == ens, "R6", {ctx, " request held"},
                {30'd0, mem_req_valid, mem_req_ns, mem_req_pa}, {30'd0, 1'b1, ens, pa});
         end
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         #1;
         chk(mem_req_valid == 1'b0, "R6", {ctx, " request dropped after accept"}, 64'(mem_req_valid), 64'd0);
         for (int i = 0; i < rsp_dly; i++) begin
            chk(fetch_done == 1'b0, "R9", {ctx, " no data before response"}, 64'(fetch_done), 64'd0);
            @(negedge clk); #1;
         end
         mem_rsp_valid = 1'b1; mem_rsp_data = dat;
         #1;
         chk(fetch_done == 1'b1 && fetch_data == dat, "R9", {ctx, " forwarded word"},
             {31'd0, fetch_done, fetch_data}, {31'd0, 1'b1, dat});
         @(negedge clk);
         mem_rsp_valid = 1'b0; fetch_valid = 1'b0;
         m_lv[li] = 1'b1; m_lns[li] = ens; m_ltag[li] = {{B_LO{1'b0}}, pa[31:B_LO]};
      end
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_clear();
      #1;
      // R1: reset state at the ports
      chk(!fetch_done && !fetch_abort && !fetch_xlate_miss && !mem_req_valid, "R1", "outputs idle after reset",
          64'({fetch_done, fetch_abort, fetch_xlate_miss, mem_req_valid}), 64'd0);
      run_fetch(32'h0001_0040, 1'b0, 1'b0, 0, 0, "R1 empty table secure");
      run_fetch(32'h0001_0040, 1'b1, 1'b0, 0, 0, "R1 empty table non-secure");

      // R2 R4 R7 R8: sweep world, descriptor NS, permissions, fetch world, user mode
      for (int cmb = 0; cmb < 64; cmb++) begin
         tlb_load(0, 20'h00010, 20'h00100, cmb[0], cmb[1], cmb[2], cmb[3]);
         run_fetch({20'h00010, 4'h0, cmb[5:0], 2'b00}, cmb[4], cmb[5], cmb % 3, cmb % 2, "R2 sweep");
         run_fetch({20'h00010, 4'h0, cmb[5:0], 2'b00}, cmb[4], cmb[5], 0, 0, "R2 sweep repeat");
      end

      // R12: two virtual pages, one physical page, lines shared
      tlb_load(1, 20'h00A00, 20'h00200, 1'b0, 1'b0, 1'b1, 1'b1);
      tlb_load(2, 20'h00B00, 20'h00200, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < B_LINES; i++) begin
         run_fetch({20'h00A00, 12'(i * 4)}, 1'b0, 1'b0, i % 2, i % 3, "R12 fill via first page");
         run_fetch({20'h00B00, 12'(i * 4)}, 1'b0, 1'b0, 0, 0, "R12 hit via alias page");
      end

      // R10: NS recorded per line; NS world copy, then secure descriptor marked NS hits it
      tlb_load(3, 20'h00C00, 20'h00200, 1'b1, 1'b0, 1'b1, 1'b1);
      tlb_load(0, 20'h00D00, 20'h00200, 1'b0, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < B_LINES; i++) begin
         run_fetch({20'h00C00, 12'(i * 4)}, 1'b1, 1'b0, 1, 0, "R10 non-secure copy");
         run_fetch({20'h00D00, 12'(i * 4)}, 1'b0, 1'b0, 0, 0, "R10 secure with NS descriptor");
         run_fetch({20'h00A00, 12'(i * 4)}, 1'b0, 1'b0, 0, 1, "R10 secure copy refetched");
      end

      // R11: table write and lookup in the same cycle
      @(negedge clk);
      tlb_wr_en = 1'b1; tlb_wr_slot = 2'd0; tlb_wr_vpn = 20'h00E00; tlb_wr_ppn = 20'h00300;
      tlb_wr_world_ns = 1'b0; tlb_wr_attr_ns = 1'b0; tlb_wr_exec_ok = 1'b1; tlb_wr_user_ok = 1'b0;
      fetch_valid = 1'b1; fetch_va = 32'h00E0_0010; core_ns = 1'b0; fetch_user = 1'b0;
      #1;
      chk(fetch_xlate_miss == 1'b1, "R11", "lookup sees old table", 64'(fetch_xlate_miss), 64'd1);
      @(negedge clk);
      tlb_wr_en = 1'b0;
      m_tv[0] = 1'b1; m_tvpn[0] = 20'h00E00; m_tppn[0] = 20'h00300;
      m_tw[0] = 1'b0; m_ta[0] = 1'b0; m_tx[0] = 1'b1; m_tu[0] = 1'b0;
      #1;
      chk(fetch_xlate_miss == 1'b0, "R11", "entry visible next cycle", 64'(fetch_xlate_miss), 64'd0);
      fetch_valid = 1'b0;
      run_fetch(32'h00E0_0010, 1'b0, 1'b0, 2, 2, "R11 after write");
      run_fetch(32'h00E0_0010, 1'b0, 1'b1, 0, 0, "R11 user fetch to supervisor page");

      // R1: reset in the middle of use clears lines and entries
      do_reset();
      run_fetch(32'h00A0_0000, 1'b0, 1'b0, 0, 0, "R1 table cleared");
      tlb_load(1, 20'h00A00, 20'h00200, 1'b0, 1'b0, 1'b1, 1'b1);
      run_fetch(32'h00A0_0000, 1'b0, 1'b0, 0, 0, "R1 lines cleared");
      run_fetch(32'h00A0_0000, 1'b0, 1'b0, 0, 0, "R1 refill hit");

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule